// File: doc/BRIEF.md
# Eight-Port Self-Routing Butterfly Fabric

This block joins a set of processor ports through a multistage butterfly of 2x2 self-routing switches. Each source presents one packet word per handshake. The upper bits of the word give the destination port index and the lower bits carry the payload and its checksum trailer. The fabric does not inspect the payload. Each stage steers on one destination bit, most significant bit first, and shifts that bit out of the header. The word that arrives at the addressed port therefore has its header fully consumed, and only the payload and checksum are presented.

The port count is a power-of-two parameter (default 8). The fabric has log2(ports) stages. Each stage holds ports/2 switches and one output register per column, so a packet makes exactly log2(ports) hops along a single fixed path. In stage s, a switch pairs the two columns that differ only in address bit (log2(ports)-1-s). The switch sends a packet to the member of the pair whose bit equals the packet's current destination bit. After the last stage the column index equals the destination. When two packets want the same switch output, a per-output round-robin arbiter picks one. A stalled output holds its word and pushes back toward the sources through valid/ready handshakes.

Top module: `bfly_fabric`

## Requirements
- R1: A packet injected at any source with destination index d (bits [PKT_W-1:DATA_W] of `src_pkt`) leaves only at output port d.
- R2: The `dst_data` word delivered equals the DATA_W low bits of the injected word unchanged, and the header field is all zero by the last stage.
- R3: With no contention and all `dst_rdy` high, a packet accepted at a rising edge shows at its output after exactly log2(PORTS) rising edges, one per stage. A conflict-free set of ports (destination = source XOR a constant) is delivered in that same cycle.
- R4: Stage s steers on destination bit (log2(PORTS)-1-s), replacing that bit of the column index. For example, source 5 to destination 2 passes columns 1 and 3 before port 2.
- R5: When two inputs of one switch want the same output in one cycle, exactly one is accepted. The other sees ready low, is held and is delivered later, with nothing lost.
- R6: Each switch output alternates priority. The input that won a contention loses the next contention for that output. Out of reset, the input from the lower column wins first.
- R7: An output with valid high and ready low keeps its valid and data stable. A full path drives the source's `src_rdy` low.
- R8: Packets from one source to one destination arrive in injection order.
- R9: During reset and right after it, no output is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| src_vld | input | PORTS | Per-source packet valid |
| src_pkt | input | PORTS x (log2(PORTS)+DATA_W) | Per-source word: destination index on top, payload and checksum below |
| src_rdy | output | PORTS | Per-source accept; handshake when valid and ready are both high |
| dst_vld | output | PORTS | Per-destination packet valid |
| dst_data | output | PORTS x DATA_W | Per-destination payload and checksum, header removed |
| dst_rdy | input | PORTS | Per-destination accept |

## Verification
A contention and an arbitration decision fall in the same cycle: two sources whose columns share a first-stage switch (0 and 4) are loaded in the same cycle with destination 0. The bench expects one of them at the output in cycle three and the other one cycle later, and the order must reverse on a repeat. Back-pressure and injection also coincide. One output is held not-ready while four packets are queued along one path, and the bench judges that the source's ready falls while the held word stays still. Random traffic with random output stalls then mixes both at every switch, and a per-source, per-destination scoreboard checks port, content and order.

// File: rtl/bfly_pkg.sv
`timescale 1ns/1ps
package bfly_pkg;
    // Column with a 0 inserted at bit position b of pair index q
    function automatic int pair_lo(int q, int b);
        return ((q >> b) << (b + 1)) | (q & ((1 << b) - 1));
    endfunction
endpackage

// File: rtl/bfly_switch.sv
`timescale 1ns/1ps
module bfly_switch #(
    parameter int DEST_W = 3,
    parameter int DATA_W = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [1:0]                          in_vld,
    input  logic [1:0][DEST_W+DATA_W-1:0]       in_word,
    output logic [1:0]                          in_rdy,
    output logic [1:0]                          out_vld,
    output logic [1:0][DEST_W+DATA_W-1:0]       out_word,
    input  logic [1:0]                          out_rdy
);
    localparam int W = DEST_W + DATA_W;

    typedef struct packed {
        logic [1:0]        vld;
        logic [1:0][W-1:0] word;
        logic [1:0]        prio;
    } sw_state_t;

    sw_state_t s_d, s_q;
    logic [1:0][1:0] req;      // req[o][k]: input k wants output o
    logic [1:0]      can_load;
    logic [1:0]      cont;
    logic [1:0]      gsel;
    logic [1:0]      load;
    logic [W-1:0]    pick;

    always_comb begin
        s_d    = s_q;
        in_rdy = '0;
        pick   = '0;
        for (int o = 0; o < 2; o++) begin
            for (int k = 0; k < 2; k++)
                req[o][k] = in_vld[k] && (in_word[k][W-1] == o[0]);
            can_load[o] = !s_q.vld[o] || out_rdy[o];
            cont[o]     = req[o][0] && req[o][1];
            gsel[o]     = cont[o] ? s_q.prio[o] : req[o][1];
            load[o]     = can_load[o] && (req[o][0] || req[o][1]);
            if (out_rdy[o])
                s_d.vld[o] = 1'b0;
            if (load[o]) begin
                pick            = in_word[gsel[o]];
                in_rdy[gsel[o]] = 1'b1;
                s_d.vld[o]      = 1'b1;
                s_d.word[o]     = {pick[W-1:DATA_W] << 1, pick[DATA_W-1:0]};
                if (cont[o])
                    s_d.prio[o] = ~gsel[o];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_vld  = s_q.vld;
    assign out_word = s_q.word;

    // One winner per contended output (R5)
    p_one_winner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld[0] && in_vld[1] && (in_word[0][W-1] == in_word[1][W-1]))
        |-> !(in_rdy[0] && in_rdy[1]));

    for (genvar o = 0; o < 2; o++) begin : g_chk
        p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (out_vld[o] && !out_rdy[o]) |=> (out_vld[o] && $stable(out_word[o])));
        for (genvar k = 0; k < 2; k++) begin : g_in
            p_steer_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (in_vld[k] && in_rdy[k] && (in_word[k][W-1] == 1'(o))) |=> out_vld[o]);
            p_alternate_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (cont[o] && in_rdy[k]) ##1 (cont[o] && can_load[o]) |-> in_rdy[1-k]);
        end
    end
endmodule

// File: rtl/bfly_stage.sv
`timescale 1ns/1ps
module bfly_stage #(
    parameter int PORTS  = 8,
    parameter int DATA_W = 16,
    parameter int STG    = 0
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic [PORTS-1:0]                              in_vld,
    input  logic [PORTS-1:0][$clog2(PORTS)+DATA_W-1:0]    in_word,
    output logic [PORTS-1:0]                              in_rdy,
    output logic [PORTS-1:0]                              out_vld,
    output logic [PORTS-1:0][$clog2(PORTS)+DATA_W-1:0]    out_word,
    input  logic [PORTS-1:0]                              out_rdy
);
    localparam int DEST_W = $clog2(PORTS);
    localparam int W      = DEST_W + DATA_W;
    localparam int B      = DEST_W - 1 - STG;   // column bit this stage replaces

    for (genvar q = 0; q < PORTS / 2; q++) begin : g_pair
        localparam int LO = bfly_pkg::pair_lo(q, B);
        localparam int HI = LO + (1 << B);
        logic [1:0]        rdy_p;
        logic [1:0]        vld_p;
        logic [1:0][W-1:0] word_p;

        bfly_switch #(.DEST_W(DEST_W), .DATA_W(DATA_W)) u_sw (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_vld   ({in_vld[HI], in_vld[LO]}),
            .in_word  ({in_word[HI], in_word[LO]}),
            .in_rdy   (rdy_p),
            .out_vld  (vld_p),
            .out_word (word_p),
            .out_rdy  ({out_rdy[HI], out_rdy[LO]})
        );

        assign in_rdy[LO]   = rdy_p[0];
        assign in_rdy[HI]   = rdy_p[1];
        assign out_vld[LO]  = vld_p[0];
        assign out_vld[HI]  = vld_p[1];
        assign out_word[LO] = word_p[0];
        assign out_word[HI] = word_p[1];
    end
endmodule

// File: rtl/bfly_fabric.sv
`timescale 1ns/1ps
module bfly_fabric #(
    parameter  int PORTS  = 8,
    parameter  int DATA_W = 16,
    localparam int DEST_W = $clog2(PORTS),
    localparam int PKT_W  = DEST_W + DATA_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [PORTS-1:0]             src_vld,
    input  logic [PORTS-1:0][PKT_W-1:0]  src_pkt,
    output logic [PORTS-1:0]             src_rdy,
    output logic [PORTS-1:0]             dst_vld,
    output logic [PORTS-1:0][DATA_W-1:0] dst_data,
    input  logic [PORTS-1:0]             dst_rdy
);
    localparam int STAGES = DEST_W;

    logic [STAGES:0][PORTS-1:0]            lvl_vld;
    logic [STAGES:0][PORTS-1:0]            lvl_rdy;
    logic [STAGES:0][PORTS-1:0][PKT_W-1:0] lvl_word;

    assign lvl_vld[0]      = src_vld;
    assign lvl_word[0]     = src_pkt;
    assign src_rdy         = lvl_rdy[0];
    assign dst_vld         = lvl_vld[STAGES];
    assign lvl_rdy[STAGES] = dst_rdy;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        bfly_stage #(.PORTS(PORTS), .DATA_W(DATA_W), .STG(s)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_vld   (lvl_vld[s]),
            .in_word  (lvl_word[s]),
            .in_rdy   (lvl_rdy[s]),
            .out_vld  (lvl_vld[s+1]),
            .out_word (lvl_word[s+1]),
            .out_rdy  (lvl_rdy[s+1])
        );
    end

    for (genvar j = 0; j < PORTS; j++) begin : g_out
        assign dst_data[j] = lvl_word[STAGES][j][DATA_W-1:0];
        // Header consumed on delivery (R2)
        p_hdr_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
            dst_vld[j] |-> (lvl_word[STAGES][j][PKT_W-1:DATA_W] == '0));
    end

    p_idle_after_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (dst_vld == '0));
endmodule

// File: tb/bfly_fabric_test.sv
`timescale 1ns/1ps
module bfly_fabric_test;
    localparam int P      = 8;
    localparam int DW     = 16;
    localparam int PW     = 3 + DW;
    localparam int WD_CYC = 20000;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [P-1:0]         src_vld = '0;
    logic [P-1:0][PW-1:0] src_pkt = '0;
    logic [P-1:0]         src_rdy;
    logic [P-1:0]         dst_vld;
    logic [P-1:0][DW-1:0] dst_data;
    logic [P-1:0]         dst_rdy = '1;

    bfly_fabric #(.PORTS(P), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .src_vld(src_vld), .src_pkt(src_pkt),
        .src_rdy(src_rdy), .dst_vld(dst_vld), .dst_data(dst_data), .dst_rdy(dst_rdy));

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int delivered = 0;
    bit done = 1'b0;
    bit rnd_bp = 1'b0;
    logic [P-1:0] rdy_mask = '1;
    logic [P-1:0] fired = '0;

    logic [PW-1:0] srcq [P][$];
    logic [DW-1:0] expq [P][P][$];

    // {src, dst, tag}
    localparam logic [18:0] VEC [8] = '{
        {3'd5, 3'd2, 13'h0A12}, {3'd0, 3'd7, 13'h1234}, {3'd7, 3'd0, 13'h0F0F},
        {3'd3, 3'd3, 13'h1FFF}, {3'd6, 3'd1, 13'h0001}, {3'd2, 3'd5, 13'h0555},
        {3'd1, 3'd6, 13'h1AAA}, {3'd4, 3'd4, 13'h0000}};

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic send(input int s, input int d, input logic [12:0] tag);
        srcq[s].push_back({3'(d), 3'(s), tag});
        expq[s][d].push_back({3'(s), tag});
    endtask

    // Source driver and output stall control
    always @(negedge clk) begin
        for (int k = 0; k < P; k++)
            if (fired[k]) void'(srcq[k].pop_front());
        for (int k = 0; k < P; k++) begin
            src_vld[k] = srcq[k].size() > 0;
            src_pkt[k] = src_vld[k] ? srcq[k][0] : '0;
        end
        for (int k = 0; k < P; k++)
            dst_rdy[k] = rnd_bp ? (($urandom % 4) != 0) : rdy_mask[k];
        #1;
        fired = src_vld & src_rdy;
    end

    // Scoreboard: port (R1), content (R2), per-pair order (R8)
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            for (int d = 0; d < P; d++) begin
                if (dst_vld[d] && dst_rdy[d]) begin
                    automatic int s = int'(dst_data[d][DW-1:DW-3]);
                    delivered++;
                    if (expq[s][d].size() == 0) begin
                        check(1'b0, "R1 misrouted", 32'(d), 32'(s));
                    end else begin
                        automatic logic [DW-1:0] e = expq[s][d].pop_front();
                        check(dst_data[d] == e, "R8 order/content", 32'(dst_data[d]), 32'(e));
                    end
                end
            end
        end
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired, actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        #2 check(dst_vld == '0, "R9 valid during reset", 32'(dst_vld), 0);
        @(posedge clk); rst_n = 1'b1;
        @(negedge clk);
        #2 check(dst_vld == '0, "R9 valid after reset", 32'(dst_vld), 0);

        // Vector table: single packets, latency R3, port R1, data R2, path R4 (5->2 first)
        for (int v = 0; v < 8; v++) begin
            automatic int s = int'(VEC[v][18:16]);
            automatic int d = int'(VEC[v][15:13]);
            automatic logic [12:0] t = VEC[v][12:0];
            @(posedge clk); send(s, d, t);
            repeat (3) @(negedge clk);
            #2 check(dst_vld == '0, "R3 early arrival", 32'(dst_vld), 0);
            @(negedge clk);
            #2 check(dst_vld == 8'(1 << d), "R1 R4 output port", 32'(dst_vld), 32'(1 << d));
            check(dst_data[d] == {3'(s), t}, "R2 payload", 32'(dst_data[d]), 32'({3'(s), t}));
        end

        // R3: conflict-free XOR permutation, all arrive together
        @(posedge clk);
        for (int k = 0; k < P; k++) send(k, k ^ 5, 13'(16 + k));
        repeat (3) @(negedge clk);
        #2 check(dst_vld == '0, "R3 early arrival xor", 32'(dst_vld), 0);
        @(negedge clk);
        #2 check(dst_vld == '1, "R3 xor permutation", 32'(dst_vld), 32'hFF);
        for (int k = 0; k < P; k++)
            check(dst_data[k ^ 5] == {3'(k), 13'(16 + k)}, "R2 xor payload",
                  32'(dst_data[k ^ 5]), 32'({3'(k), 13'(16 + k)}));

        // R5/R6: sources 0 and 4 contend for stage-0 output toward port 0
        for (int r = 0; r < 2; r++) begin
            automatic int first  = (r == 0) ? 0 : 4;
            automatic int second = (r == 0) ? 4 : 0;
            @(negedge clk); @(posedge clk);
            send(0, 0, 13'(100 + r)); send(4, 0, 13'(200 + r));
            repeat (4) @(negedge clk);
            #2 check(dst_vld == 8'h01, "R5 one winner", 32'(dst_vld), 32'h01);
            check(dst_data[0][DW-1:DW-3] == 3'(first), (r == 0) ? "R5 first winner" : "R6 alternation",
                  32'(dst_data[0][DW-1:DW-3]), 32'(first));
            @(negedge clk);
            #2 check(dst_vld == 8'h01, "R5 loser held then delivered", 32'(dst_vld), 32'h01);
            check(dst_data[0][DW-1:DW-3] == 3'(second), (r == 0) ? "R5 second" : "R6 second",
                  32'(dst_data[0][DW-1:DW-3]), 32'(second));
        end

        // R7: stall port 2, queue four packets 5->2
        @(negedge clk); rdy_mask = 8'hFB;
        @(posedge clk);
        for (int n = 0; n < 4; n++) send(5, 2, 13'(300 + n));
        repeat (5) @(negedge clk);
        #2 check(dst_vld[2] == 1'b1, "R7 held valid", 32'(dst_vld[2]), 1);
        check(dst_data[2] == {3'd5, 13'(300)}, "R7 held data", 32'(dst_data[2]), 32'({3'd5, 13'(300)}));
        check(src_vld[5] && !src_rdy[5], "R7 source stalled", 32'(src_rdy[5]), 0);
        repeat (3) @(negedge clk);
        #2 check(dst_data[2] == {3'd5, 13'(300)} && dst_vld[2], "R7 stable under stall",
                 32'(dst_data[2]), 32'({3'd5, 13'(300)}));
        rdy_mask = '1;
        repeat (8) @(negedge clk);

        // R8/R1: random traffic with random output stalls
        @(posedge clk);
        rnd_bp = 1'b1;
        for (int k = 0; k < P; k++)
            for (int n = 0; n < 30; n++) send(k, int'($urandom % P), 13'(1000 + n));
        begin
            automatic bit busy = 1'b1;
            while (busy) begin
                @(negedge clk);
                busy = 1'b0;
                for (int k = 0; k < P; k++) begin
                    if (srcq[k].size() != 0) busy = 1'b1;
                    for (int d = 0; d < P; d++)
                        if (expq[k][d].size() != 0) busy = 1'b1;
                end
            end
        end
        rnd_bp = 1'b0;
        repeat (4) @(negedge clk);
        #2 check(dst_vld == '0, "R1 all drained", 32'(dst_vld), 0);
        check(delivered == 8 + 8 + 4 + 4 + 240, "R1 delivered count", 32'(delivered), 264);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule